// File: doc/BRIEF.md
# Decimal Fractional Divide Accumulator

This block is the fractional half of a fractional-N synthesizer controller. A frequency word of seven BCD decades is written into a holding register. The upper three decades give the integer divide ratio N, which must lie between 400 and 700. The lower four decades give a fractional part, in steps of 0.0001 of one reference step. Each write is checked: a word that holds a digit above 9, or an integer part outside the allowed range, raises an error flag and is not kept.

On a reference tick with the load strobe high, the held word becomes the active word and the decimal phase register is cleared. On every other reference tick the fractional decades are added into the phase register with decimal carries. The carry out of the top fractional decade is the skip command, and it selects N+1 for that reference period. In the same clock edge that produces a skip, the phase register's new content is put on the residue output, so that the phase-jump correction logic always sees the value that belongs to the current divide ratio. Between ticks all outputs hold.

For example, 435.0100 gives 435 for 99 periods and 436 once in every 100, which is a 1 kHz pattern at a 100 kHz reference. The value 435.5000 alternates between 435 and 436.

Top module: `bcd_frac_accum`

## Requirements
- R1: A synchronous reset clears residue, skip, div_ratio, digit_err, the holding register and the active word to zero.
- R2: On freq_wr, a word whose seven digits are all 0..9 and whose integer value is between 400 and 700 inclusive is stored and clears digit_err one cycle later. Any other word sets digit_err one cycle later and leaves the holding register unchanged. freq_in[27:24] is the hundreds digit, freq_in[15:12] is the most significant fractional digit and freq_in[3:0] is the least.
- R3: A written word has no effect on the outputs until a tick with load high, and load without tick has no effect.
- R4: On a tick with load high, the held word becomes active. One cycle later residue is 0, skip is 0 and div_ratio is N in binary.
- R5: On a tick with load low, with P the residue read as a decimal number and F the active fraction, residue becomes (P+F) mod 10000 in BCD and skip becomes 1 exactly when P+F is at least 10000. div_ratio becomes N+skip. All of these update in the same cycle.
- R6: In cycles without a tick, residue, skip and div_ratio keep their values.
- R7: A fraction of 0.0100 produces exactly one skip in every 100 ticks.
- R8: A fraction of zero never produces a skip, and div_ratio stays at N. This includes the range ends 400 and 700.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Reference tick, one cycle per reference period |
| freq_wr | input | 1 | Write freq_in into the holding register |
| freq_in | input | 28 | Seven-decade BCD word: three integer decades over four fractional decades |
| load | input | 1 | Apply the held word on the current tick |
| div_ratio | output | 10 | Integer divide ratio for this period (N or N+1), binary |
| skip | output | 1 | High while N+1 is selected |
| residue | output | 16 | Phase register content, four BCD digits |
| digit_err | output | 1 | The last written word was rejected |

## Verification
The bench builds the block with its default parameters: three integer decades, four fractional decades and the range 400 to 700. With four decades, a fraction of 0.0100 wraps the phase register every 100 ticks, so a 200-tick run shows the 1 kHz skip pattern twice. The same settings make it possible to test 0.5000 alternation, 0.9999 near-constant skipping, both ends of the integer range, and words just outside it (399, 701, and a non-decimal digit).

// File: rtl/bcd_frac_pkg.sv
package bcd_frac_pkg;

  function automatic logic digit_ok(input logic [3:0] d);
    return d <= 4'd9;
  endfunction

  // {carry, sum} of two BCD digits plus a carry in
  function automatic logic [4:0] digit_add(input logic [3:0] a, input logic [3:0] b,
                                           input logic cin);
    logic [4:0] raw;
    logic [4:0] fixed;
    raw = {1'b0, a} + {1'b0, b} + {4'd0, cin};
    fixed = raw - 5'd10;
    if (raw > 5'd9) return {1'b1, fixed[3:0]};
    return {1'b0, raw[3:0]};
  endfunction

endpackage

// File: rtl/bcd_word_check.sv
module bcd_word_check #(
  parameter int INT_DIGITS  = 3,
  parameter int FRAC_DIGITS = 4,
  parameter int N_MIN       = 400,
  parameter int N_MAX       = 700
) (
  input  logic [4*(INT_DIGITS+FRAC_DIGITS)-1:0] word,
  output logic                                  word_ok
);
  import bcd_frac_pkg::*;
  localparam int DIGITS = INT_DIGITS + FRAC_DIGITS;

  logic [DIGITS-1:0] dig_good;
  int                int_value;
  logic              in_range;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    assign dig_good[i] = digit_ok(word[4*i +: 4]);
  end

  always_comb begin
    int_value = 0;
    for (int k = DIGITS - 1; k >= FRAC_DIGITS; k--)
      int_value = int_value * 10 + int'(word[4*k +: 4]);
  end

  assign in_range = (int_value >= N_MIN) && (int_value <= N_MAX);
  assign word_ok  = (&dig_good) && in_range;
endmodule

// File: rtl/bcd_adder.sv
module bcd_adder #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] a,
  input  logic [4*DIGITS-1:0] b,
  output logic [4*DIGITS-1:0] sum,
  output logic                cout
);
  import bcd_frac_pkg::*;

  logic [DIGITS:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < DIGITS; i++) begin : g_stage
    logic [4:0] res;
    assign res            = digit_add(a[4*i +: 4], b[4*i +: 4], carry[i]);
    assign sum[4*i +: 4]  = res[3:0];
    assign carry[i+1]     = res[4];
  end

  assign cout = carry[DIGITS];
endmodule

// File: rtl/divide_select.sv
module divide_select #(
  parameter int INT_DIGITS = 3,
  parameter int DIV_W      = 10
) (
  input  logic [4*INT_DIGITS-1:0] int_bcd,
  input  logic                    bump,
  output logic [DIV_W-1:0]        ratio
);
  int value;

  always_comb begin
    value = 0;
    for (int k = INT_DIGITS - 1; k >= 0; k--)
      value = value * 10 + int'(int_bcd[4*k +: 4]);
    value = value + int'(bump);
    ratio = DIV_W'(value);
  end
endmodule

// File: rtl/bcd_frac_accum.sv
module bcd_frac_accum #(
  parameter int INT_DIGITS  = 3,
  parameter int FRAC_DIGITS = 4,
  parameter int N_MIN       = 400,
  parameter int N_MAX       = 700,
  localparam int INT_W      = 4 * INT_DIGITS,
  localparam int FRAC_W     = 4 * FRAC_DIGITS,
  localparam int WORD_W     = INT_W + FRAC_W,
  localparam int DIV_W      = $clog2(N_MAX + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              freq_wr,
  input  logic [WORD_W-1:0] freq_in,
  input  logic              load,
  output logic [DIV_W-1:0]  div_ratio,
  output logic              skip,
  output logic [FRAC_W-1:0] residue,
  output logic              digit_err
);
  logic [WORD_W-1:0] hold_word;
  logic [WORD_W-1:0] act_word;
  logic [FRAC_W-1:0] acc_q;
  logic              skip_q;
  logic [DIV_W-1:0]  div_q;
  logic              err_q;

  // named events for the checker
  logic              word_ok;
  logic              wr_bad;
  logic              load_step;
  logic              run_step;
  logic [FRAC_W-1:0] acc_next;
  logic              acc_cout;
  logic [DIV_W-1:0]  run_ratio;
  logic [DIV_W-1:0]  load_ratio;

  bcd_word_check #(
    .INT_DIGITS(INT_DIGITS), .FRAC_DIGITS(FRAC_DIGITS), .N_MIN(N_MIN), .N_MAX(N_MAX)
  ) u_check (
    .word(freq_in), .word_ok(word_ok)
  );

  bcd_adder #(.DIGITS(FRAC_DIGITS)) u_add (
    .a(acc_q), .b(act_word[FRAC_W-1:0]), .sum(acc_next), .cout(acc_cout)
  );

  divide_select #(.INT_DIGITS(INT_DIGITS), .DIV_W(DIV_W)) u_sel_run (
    .int_bcd(act_word[WORD_W-1:FRAC_W]), .bump(acc_cout), .ratio(run_ratio)
  );

  divide_select #(.INT_DIGITS(INT_DIGITS), .DIV_W(DIV_W)) u_sel_load (
    .int_bcd(hold_word[WORD_W-1:FRAC_W]), .bump(1'b0), .ratio(load_ratio)
  );

  assign wr_bad    = freq_wr && !word_ok;
  assign load_step = tick && load;
  assign run_step  = tick && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_word <= '0;
      act_word  <= '0;
      acc_q     <= '0;
      skip_q    <= 1'b0;
      div_q     <= '0;
      err_q     <= 1'b0;
    end else begin
      if (freq_wr) begin
        err_q <= !word_ok;
        if (word_ok) hold_word <= freq_in;
      end
      if (load_step) begin
        act_word <= hold_word;
        acc_q    <= '0;
        skip_q   <= 1'b0;
        div_q    <= load_ratio;
      end else if (run_step) begin
        acc_q    <= acc_next;
        skip_q   <= acc_cout;
        div_q    <= run_ratio;
      end
    end
  end

  assign residue   = acc_q;
  assign skip      = skip_q;
  assign div_ratio = div_q;
  assign digit_err = err_q;
endmodule

// File: rtl/bcd_frac_accum_chk.sv
module bcd_frac_accum_chk #(
  parameter int FRAC_DIGITS = 4,
  parameter int N_MIN       = 400,
  parameter int N_MAX       = 700,
  parameter int WORD_W      = 28,
  parameter int DIV_W       = 10
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     tick,
  input logic                     skip,
  input logic [4*FRAC_DIGITS-1:0] residue,
  input logic [DIV_W-1:0]         div_ratio,
  input logic                     wr_bad,
  input logic [WORD_W-1:0]        hold_word,
  input logic                     load_step,
  input logic                     run_step
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (residue == '0) && !skip && (div_ratio == '0));

  p_bad_word_kept_r2: assert property (@(posedge clk) disable iff (rst)
    wr_bad |=> $stable(hold_word));

  p_load_clears_r4: assert property (@(posedge clk) disable iff (rst)
    load_step |=> (residue == '0) && !skip);

  p_skip_on_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    run_step |=> (skip == (residue < $past(residue))));

  p_skip_ratio_range_r5: assert property (@(posedge clk) disable iff (rst)
    skip |-> (int'(div_ratio) > N_MIN) && (int'(div_ratio) <= N_MAX + 1));

  p_hold_between_r6: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(residue) && $stable(skip) && $stable(div_ratio));

  for (genvar i = 0; i < FRAC_DIGITS; i++) begin : g_res
    p_residue_digit_r5: assert property (@(posedge clk) disable iff (rst)
      residue[4*i +: 4] <= 4'd9);
  end
endmodule

bind bcd_frac_accum bcd_frac_accum_chk #(
  .FRAC_DIGITS(FRAC_DIGITS), .N_MIN(N_MIN), .N_MAX(N_MAX), .WORD_W(WORD_W), .DIV_W(DIV_W)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .skip(skip), .residue(residue),
  .div_ratio(div_ratio), .wr_bad(wr_bad), .hold_word(hold_word),
  .load_step(load_step), .run_step(run_step)
);

// File: tb/bcd_frac_accum_test.sv
module bcd_frac_accum_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        freq_wr = 1'b0;
  logic [27:0] freq_in = '0;
  logic        load = 1'b0;
  logic [9:0]  div_ratio;
  logic        skip;
  logic [15:0] residue;
  logic        digit_err;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  int m_hold_n = 0, m_hold_f = 0, m_n = 0, m_f = 0, m_acc = 0, m_skip = 0, m_div = 0;

  always #2 clk = ~clk;

  bcd_frac_accum uut (
    .clk(clk), .rst(rst), .tick(tick), .freq_wr(freq_wr), .freq_in(freq_in),
    .load(load), .div_ratio(div_ratio), .skip(skip), .residue(residue),
    .digit_err(digit_err)
  );

  function automatic int dec_of(input logic [15:0] v, input int n);
    int r = 0;
    int scale = 1;
    for (int i = 0; i < n; i++) begin
      r = r + scale * int'(v[4*i +: 4]);
      scale = scale * 10;
    end
    return r;
  endfunction

  function automatic logic [27:0] mk(input int n, input int f);
    logic [27:0] w;
    w[27:24] = 4'(n / 100);       w[23:20] = 4'((n / 10) % 10); w[19:16] = 4'(n % 10);
    w[15:12] = 4'(f / 1000);      w[11:8]  = 4'((f / 100) % 10);
    w[7:4]   = 4'((f / 10) % 10); w[3:0]   = 4'(f % 10);
    return w;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    check(req, dec_of(residue, 4), m_acc);
    check(req, int'(skip), m_skip);
    check(req, int'(div_ratio), m_div);
  endtask

  task automatic write_word(input logic [27:0] w, input bit ok);
    @(negedge clk); freq_in = w; freq_wr = 1'b1;
    @(negedge clk); freq_wr = 1'b0;
    if (ok) begin
      m_hold_n = 100 * int'(w[27:24]) + 10 * int'(w[23:20]) + int'(w[19:16]);
      m_hold_f = dec_of(w[15:0], 4);
    end
    check("R2 digit_err", int'(digit_err), ok ? 0 : 1);
  endtask

  // one reference tick; then check outputs, then check they hold one idle cycle
  task automatic do_tick(input bit ld, input string req);
    @(negedge clk); tick = 1'b1; load = ld;
    @(negedge clk); tick = 1'b0; load = 1'b0;
    if (ld) begin
      m_n = m_hold_n; m_f = m_hold_f; m_acc = 0; m_skip = 0; m_div = m_n;
    end else begin
      m_skip = (m_acc + m_f >= 10000) ? 1 : 0;
      m_acc  = (m_acc + m_f) % 10000;
      m_div  = m_n + m_skip;
    end
    check_outputs(req);
    @(negedge clk);
    check_outputs("R6 hold");
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    m_hold_n = 0; m_hold_f = 0; m_n = 0; m_f = 0; m_acc = 0; m_skip = 0; m_div = 0;
    check_outputs("R1 reset");
    check("R1 digit_err", int'(digit_err), 0);
  endtask

  task automatic t_one_percent();
    int skips = 0;
    int last = -1;
    int gap_bad = 0;
    write_word(mk(435, 100), 1);
    do_tick(1, "R4 load");
    for (int i = 1; i <= 200; i++) begin
      do_tick(0, "R5 run");
      if (skip) begin
        if (last >= 0 && i - last != 100) gap_bad++;
        last = i;
        skips++;
      end
    end
    check("R7 skip count", skips, 2);
    check("R7 skip period", gap_bad, 0);
  endtask

  task automatic t_half();
    write_word(mk(435, 5000), 1);
    do_tick(1, "R4 load");
    for (int i = 0; i < 6; i++) do_tick(0, "R5 half");
  endtask

  task automatic t_near_full();
    write_word(mk(612, 9999), 1);
    do_tick(1, "R4 load");
    for (int i = 0; i < 5; i++) do_tick(0, "R5 near full");
  endtask

  task automatic t_zero_frac();
    int any = 0;
    write_word(mk(700, 0), 1);
    do_tick(1, "R4 load 700");
    for (int i = 0; i < 8; i++) begin do_tick(0, "R8 zero"); any += int'(skip); end
    write_word(mk(400, 0), 1);
    do_tick(1, "R4 load 400");
    for (int i = 0; i < 8; i++) begin do_tick(0, "R8 zero"); any += int'(skip); end
    check("R8 no skip", any, 0);
  endtask

  task automatic t_bad_words();
    logic [27:0] w;
    write_word(mk(500, 2500), 1);
    w = mk(450, 1234); w[7:4] = 4'hA;
    write_word(w, 0);
    write_word(mk(399, 0), 0);
    write_word(mk(701, 0), 0);
    w = mk(500, 0); w[23:20] = 4'hF;
    write_word(w, 0);
    do_tick(1, "R2 kept word");
    do_tick(0, "R2 kept word");
    check("R2 kept N", int'(div_ratio), 500);
  endtask

  task automatic t_no_early_apply();
    write_word(mk(520, 3000), 1);
    do_tick(1, "R4 load");
    write_word(mk(680, 7000), 1);
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
    check_outputs("R3 load without tick");
    do_tick(0, "R3 old word");
    do_tick(0, "R3 old word");
    check("R3 N still old", int'(div_ratio) - int'(skip), 520);
    do_tick(1, "R3 applied");
    do_tick(0, "R3 new word");
  endtask

  task automatic t_mid_reset();
    write_word(mk(555, 3333), 1);
    do_tick(1, "R4 load");
    do_tick(0, "R5 run");
    do_tick(0, "R5 run");
    do_reset();
    do_tick(1, "R1 held cleared");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_outputs("R1 reset");
    check("R1 digit_err", int'(digit_err), 0);
    t_one_percent();
    t_half();
    t_near_full();
    t_zero_frac();
    t_bad_words();
    t_no_early_apply();
    t_mid_reset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule